// File: doc/BRIEF.md
# SPI Register-Access Target with Address Auto-Increment

This block lets an external SPI host read and write a 128-entry, 8-bit register space. The host lowers the active-low select and sends a command byte first. That byte's top bit picks the direction and its lower seven bits give the starting address. Each further byte sent while select stays low moves to the next address, and the address rolls over from 0x7F to 0x00. Raising select ends the frame. Any byte that was only partly shifted in is dropped, and the next frame starts again with a command byte.

All three serial inputs (serial clock, select, host data) pass through two-flop synchronizers into the system clock domain. The system clock must run at least four times faster than the serial clock. On the local side, a plain register port presents an address, write data and a one-cycle write strobe. Read data comes back combinationally for the address being presented. This port has no back-pressure: the register file must take every strobe in the cycle it is given and must always answer reads. The serial output has a separate enable, so the pad can be tri-stated while the block is deselected.

Top module: `spi_regport_target`

## Requirements
- R1: While select (`spi_cs_n`) is high, `spi_miso_en` is 0 and `reg_we` stays 0, whatever `spi_sclk` and `spi_mosi` do.
- R2: Once select has been low for more than three system clocks, `spi_miso_en` is 1 until select rises again.
- R3: Bytes travel most significant bit first. The first byte of a frame is the command: bit 7 = 1 means write, bit 7 = 0 means read, and bits 6:0 hold the start address.
- R4: In a write frame, every fully received data byte gives exactly one single-cycle `reg_we` pulse. `reg_wdata` carries the byte and `reg_addr` carries its target address.
- R5: Each later data byte in the same frame targets the previous address plus one.
- R6: The address after 0x7F is 0x00, for both reads and writes.
- R7: When select rises in the middle of a byte, that byte is discarded and no write is issued for it. The next frame always starts with a command byte.
- R8: In a read frame, the register at the start address is fetched after the command byte. Its MSB appears on `spi_miso` at the falling serial-clock edge that follows the command's eighth rising edge. Later bits change on falling edges, and the host samples them on rising edges.
- R9: In a read frame, each further byte returns the register at the next address. That register is fetched as soon as the previous byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_en | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | 7 | Register address on the local port |
| reg_wdata | output | 8 | Write data on the local port |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
Two events can land together: the pointer roll-over from 0x7F to 0x00, and the write strobe or read prefetch it feeds. The bench provokes this by writing three bytes starting at 0x7E and then reading two bytes starting at 0x7F. The scoreboard expects address 0x00 for the third write and for the second read byte. A second collision is select rising right after a byte: a select release just after a completed byte must still produce that byte's strobe. A release three bits into the next byte must produce none, and the frame that follows must decode a fresh command.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rp_edge.sv
module spi_rp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_rp_engine.sv
module spi_rp_engine
  import spi_rp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic              rise,
  input  logic              fall,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              miso,
  output logic              miso_en
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_e            phase;
  logic              is_wr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              ld_q;
  logic              miso_q;
  logic              en_q;

  logic              byte_done;
  logic [DATA_W-1:0] rx_byte;

  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_done = !cs_s && rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      is_wr   <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      ld_q    <= 1'b0;
      miso_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      ld_q <= 1'b0;
      en_q <= !cs_s;
      // step the pointer once the strobe has been presented at the old address
      if (we_q) ptr <= ptr + ADDR_W'(1);
      if (ld_q) tx_sh <= reg_rdata;
      if (cs_s) begin
        phase   <= PH_CMD;
        is_wr   <= 1'b0;
        bit_cnt <= '0;
      end else begin
        if (rise) begin
          rx_sh   <= rx_byte[DATA_W-2:0];
          bit_cnt <= byte_done ? '0 : bit_cnt + CNT_W'(1);
          if (byte_done) begin
            if (phase == PH_CMD) begin
              phase <= PH_DATA;
              is_wr <= rx_byte[DATA_W-1];
              ptr   <= rx_byte[ADDR_W-1:0];
              ld_q  <= !rx_byte[DATA_W-1];
            end else if (is_wr) begin
              we_q    <= 1'b1;
              wdata_q <= rx_byte;
            end else begin
              ptr  <= ptr + ADDR_W'(1);
              ld_q <= 1'b1;
            end
          end
        end
        if (fall) begin
          miso_q <= tx_sh[DATA_W-1];
          tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign miso      = miso_q;
  assign miso_en   = en_q;
endmodule

// File: rtl/spi_regport_target.sv
module spi_regport_target #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [2:0] raw_in;
  logic [2:0] syn_out;
  logic       sclk_s;
  logic       cs_s;
  logic       mosi_s;
  logic       rise;
  logic       fall;

  assign raw_in = {spi_sclk, spi_cs_n, spi_mosi};
  assign {sclk_s, cs_s, mosi_s} = syn_out;

  spi_rp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out)
  );

  spi_rp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(rise), .fall(fall)
  );

  spi_rp_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .mosi_s(mosi_s),
    .rise(rise), .fall(fall),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .miso(spi_miso), .miso_en(spi_miso_en)
  );
endmodule

// File: rtl/spi_rp_chk.sv
module spi_rp_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              fall,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              spi_miso,
  input logic              spi_miso_en
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!spi_miso_en && !reg_we));

  assert_drive_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> spi_miso_en);

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // covers R6 as well: the 7-bit sum rolls 0x7F over to 0x00
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

  assert_miso_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(spi_miso));
endmodule

bind spi_regport_target spi_rp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall(fall),
  .reg_we(reg_we), .reg_addr(reg_addr),
  .spi_miso(spi_miso), .spi_miso_en(spi_miso_en)
);

// File: tb/sim_spi_regport_target.sv
module sim_spi_regport_target;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic       spi_miso_en;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;

  int total = 0;
  int bad = 0;

  logic [7:0]  regs   [128];
  logic [7:0]  shadow [128];
  logic [14:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  spi_regport_target u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regs[reg_addr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // register file model plus scoreboard monitor
  initial begin
    for (int i = 0; i < 128; i++) regs[i] = 8'(i) ^ 8'h5C;
    forever begin
      @(negedge clk);
      if (rst_n && reg_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1/R4/R7 unexpected write", {reg_addr, reg_wdata}, 0);
        end else begin
          logic [14:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({reg_addr, reg_wdata} == e, t, {reg_addr, reg_wdata}, e);
        end
        regs[reg_addr] = reg_wdata;
      end
    end
  end

  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      #80;
      got[i] = spi_miso;
      spi_sclk = 1'b1;
      #80;
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_open();
    spi_cs_n = 1'b0;
    #160;
    check(spi_miso_en == 1'b1, "R2 miso enable in frame", spi_miso_en, 1);
  endtask

  task automatic frame_close();
    #160;
    spi_cs_n = 1'b1;
    #400;
    check(spi_miso_en == 1'b0, "R1 miso enable after frame", spi_miso_en, 0);
  endtask

  task automatic write_frame(input logic [6:0] a, input logic [7:0] d[], input string tag);
    logic [7:0] junk;
    logic [6:0] p;
    p = a;
    frame_open();
    xfer_byte({1'b1, a}, junk);
    foreach (d[k]) begin
      exp_q.push_back({p, d[k]});
      tag_q.push_back(tag);
      shadow[p] = d[k];
      xfer_byte(d[k], junk);
      p = p + 7'd1;
    end
    frame_close();
  endtask

  task automatic read_frame(input logic [6:0] a, input int n, input string tag);
    logic [7:0] got;
    logic [6:0] p;
    p = a;
    frame_open();
    xfer_byte({1'b0, a}, got);
    for (int k = 0; k < n; k++) begin
      xfer_byte(8'h00, got);
      check(got == shadow[p], tag, got, shadow[p]);
      p = p + 7'd1;
    end
    frame_close();
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] junk;
    for (int i = 0; i < 128; i++) shadow[i] = 8'(i) ^ 8'h5C;
    #42;
    rst_n = 1'b1;
    #100;
    check(spi_miso_en == 1'b0, "R1 reset miso enable", spi_miso_en, 0);
    check(reg_we == 1'b0, "R1 reset write strobe", reg_we, 0);

    // R1: serial activity with select high must do nothing
    for (int i = 0; i < 24; i++) begin
      spi_mosi = i[0];
      #80;
      spi_sclk = ~spi_sclk;
      check(spi_miso_en == 1'b0, "R1 deselected enable", spi_miso_en, 0);
    end
    spi_sclk = 1'b0;
    #200;

    // R3/R4 single write
    write_frame(7'h10, '{8'hA5}, "R3/R4 single write");
    // R5 burst write
    write_frame(7'h20, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5 burst write");
    // R6 wrap on write
    write_frame(7'h7E, '{8'hE1, 8'hE2, 8'hE3}, "R6 write wrap");

    // R7 partial byte dropped
    exp_q.push_back({7'h30, 8'h5A});
    tag_q.push_back("R7 byte before abort");
    shadow[7'h30] = 8'h5A;
    frame_open();
    xfer_byte(8'hB0, junk);
    xfer_byte(8'h5A, junk);
    for (int i = 2; i >= 0; i--) begin
      spi_mosi = 1'b1;
      #80;
      spi_sclk = 1'b1;
      #80;
      spi_sclk = 1'b0;
    end
    frame_close();
    check(regs[7'h31] == shadow[7'h31], "R7 partial byte not written", regs[7'h31], shadow[7'h31]);
    // R7 next frame starts with a command
    write_frame(7'h40, '{8'hC3}, "R7 fresh command after abort");

    // R8 single read, R9 burst read, R6 wrap on read
    read_frame(7'h10, 1, "R8 first read byte");
    read_frame(7'h20, 4, "R9 burst read");
    read_frame(7'h7F, 2, "R6/R9 read wrap");
    read_frame(7'h05, 2, "R8/R9 untouched registers");

    // R7 aborted read then write still decodes the command
    frame_open();
    xfer_byte(8'h12, junk);
    xfer_byte(8'h00, junk);
    spi_mosi = 1'b0;
    #80;
    spi_sclk = 1'b1;
    #80;
    spi_sclk = 1'b0;
    frame_close();
    write_frame(7'h12, '{8'h9D}, "R7 write after aborted read");
    read_frame(7'h12, 1, "R7 readback after abort");

    #400;
    check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule